// File: doc/BRIEF.md
# DMA-Priority DRAM Cycle Arbiter

This block shares one bank of dynamic RAM between a disk DMA engine and a 68000-style CPU bus. The DMA engine has priority. A single fast master clock feeds a free-running divider, which yields the CPU-rate clock and its slower companions. CPU RAM cycles are aligned to one fixed phase of the two fastest divided clocks. Because of this alignment, handing the RAM back from DMA to the CPU never requires the CPU to resynchronise.

The arbiter produces the per-row RAS strobes, the per-byte CAS strobes, the row/column address multiplexer select, the CPU-side data buffer enable and DTACK.

- **CPU cycle already running:** a DMA request is held off until the cycle's address strobe is released. The request stays pending meanwhile.
- **CPU cycle arriving while DMA owns the RAM:** the cycle is stretched. The data buffer stays disabled and DTACK is withheld until the DMA ends and the start phase comes round again.
- **Serial-controller region:** accesses take two extra CPU-clock periods before DTACK.

Top module: `dram_cycle_arbiter`

## Requirements
- R1: `div_clk` is a free-running binary count of master clock edges. Bit k divides the master clock by 2^(k+1), which gives /2, /4, /8 and /16. The count is 0 during reset and advances by exactly 1 at every master edge after reset.
- R2: A CPU access cycle starts only at a "phase edge": a master edge where, before the edge, `div_clk[0]`=1 (CPU-rate clock high) and `div_clk[1]`=0 (half-rate clock low), and `as_n` is low. A strobe asserted at any other phase waits for the next phase edge.
- R3: A RAM cycle (`ram_sel`=1) that starts without DMA has the following timing:
  - From the start edge: `ras_n[bank_sel]` is low, `rcmux`=0 (row) and `buf_en`=1.
  - One edge later: `rcmux`=1 (column).
  - Two edges later: the selected CAS bits and `dtack_n` go low.
  - After `as_n` goes high, all of these are released at the next edge.
- R4: CAS mapping. `cas_n[2*row+1]` is the upper byte and follows `uds_n`. `cas_n[2*row]` is the lower byte and follows `lds_n`. Only the strobes that are low at the start edge are driven.
- R5: `dma_gnt` rises at a phase edge where `dma_req` is high, no RAS is active and no CPU RAM cycle holds or claims the RAM.
- R6: `dma_gnt` falls only at a phase edge where `dma_req` is low. Otherwise it stays high.
- R7: While a CPU RAM cycle is running, or starting on the same edge, the grant is held off. It cannot rise before the edge after `as_n` returns high. The request stays pending and is granted at a later phase edge.
- R8: A RAM cycle that starts while `dma_gnt`=1 is stretched:
  - During the stretch, no RAS is asserted, `buf_en`=0 and `dtack_n`=1.
  - The stretch ends at the first phase edge where `dma_gnt` was already low.
  - From that edge the R3 timing runs.
- R9: While `dma_gnt`=1, both CAS bits of the top row (row ROWS-1) equal the inverse of `dma_wp`, combinationally. All other CAS bits stay high.
- R10: A serial-controller access (`per_sel`=1, `ram_sel`=0) drives `dtack_n` low 6 edges after its start edge. That is four master cycles, or two CPU-clock periods, later than a RAM cycle. Such an access asserts no RAS and no CAS.
- R11: Synchronous active-high `rst` returns the block to idle with the CPU as owner. After reset, all RAS and CAS are high, `dtack_n`=1, `buf_en`=0, `rcmux`=0, `dma_gnt`=0 and `div_clk`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | CPU address strobe, active low |
| uds_n | input | 1 | CPU upper byte strobe, active low |
| lds_n | input | 1 | CPU lower byte strobe, active low |
| ram_sel | input | 1 | Address decodes to RAM |
| per_sel | input | 1 | Address decodes to the serial-controller region |
| bank_sel | input | ROW_W | RAM row addressed by the CPU |
| dma_req | input | 1 | DMA request from the disk engine |
| dma_wp | input | 1 | DMA write pulse, drives the top-row CAS during DMA |
| div_clk | output | DIV_STAGES | Divided clocks: /2, /4, /8, /16 |
| dma_gnt | output | 1 | RAM granted to DMA |
| ras_n | output | ROWS | Row strobes, one per RAM row, active low |
| cas_n | output | 2*ROWS | Column strobes, two per row (lower, upper), active low |
| rcmux | output | 1 | Address multiplexer select: 0 row, 1 column |
| buf_en | output | 1 | CPU-side RAM data buffer enable |
| dtack_n | output | 1 | Data acknowledge to the CPU, active low |

## Verification
Every result lands at a fixed offset from a phase edge, and the bench aligns to that edge by watching `div_clk`:

| Result | Due |
|---|---|
| RAS, row select and buffer enable | the start edge itself |
| Column select | one edge after start |
| CAS and RAM DTACK | two edges after start |
| Serial-controller DTACK | six edges after start |
| Grant changes | only at phase edges, four master cycles apart |

Inputs are driven on the falling clock edge. Outputs are sampled on later falling edges counted from the phase edge, so every check reads a settled value exactly in the cycle it is due. The DMA CAS follows `dma_wp` combinationally and is sampled one time step after the pulse changes.

// File: rtl/dram_arb_pkg.sv
package dram_arb_pkg;

    // Divider bit positions of the CPU-rate clock and its half-rate companion.
    localparam int CPU_CLK_BIT  = 0;
    localparam int HALF_CLK_BIT = 1;

    // Extra CPU-clock periods before acknowledging a serial-controller access.
    localparam int PER_EXTRA_CPU_CLKS = 2;

    typedef enum logic [1:0] {
        CYC_IDLE    = 2'd0,
        CYC_STRETCH = 2'd1,
        CYC_RUN     = 2'd2
    } cyc_state_t;

    typedef enum logic {
        ACC_RAM = 1'b0,
        ACC_PER = 1'b1
    } acc_kind_t;

    typedef struct packed {
        acc_kind_t kind;
        logic      upper;
        logic      lower;
    } acc_t;

    // Legal start phase: CPU-rate clock high while the half-rate clock is low.
    function automatic logic start_phase(input logic cpu_clk, input logic half_clk);
        return cpu_clk & ~half_clk;
    endfunction

endpackage

// File: rtl/clk_divider.sv
module clk_divider
    import dram_arb_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic [STAGES-1:0] div,
    output logic              phase_ok
);

    always_ff @(posedge clk) begin
        if (rst) div <= '0;
        else     div <= div + STAGES'(1);
    end

    assign phase_ok = start_phase(div[CPU_CLK_BIT], div[HALF_CLK_BIT]);

    // R1: the divider advances by one each master edge
    a_r1_div_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> div == $past(div) + STAGES'(1));

endmodule

// File: rtl/dma_grant.sv
module dma_grant (
    input  logic clk,
    input  logic rst,
    input  logic phase_ok,
    input  logic dma_req,
    input  logic cpu_claim,
    input  logic ras_any,
    output logic gnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt <= 1'b0;
        end else if (phase_ok) begin
            if (!gnt && dma_req && !cpu_claim && !ras_any) gnt <= 1'b1;
            else if (gnt && !dma_req)                     gnt <= 1'b0;
        end
    end

    // R5/R6: ownership changes only at the start phase
    a_r6_gnt_on_phase: assert property (@(posedge clk) disable iff (rst)
        (gnt != $past(gnt)) |-> $past(phase_ok));

endmodule

// File: rtl/cpu_cycle.sv
module cpu_cycle
    import dram_arb_pkg::*;
#(
    parameter int ROWS      = 2,
    parameter int ROW_W     = 1,
    parameter int RAM_DTACK = 2,
    parameter int CAS_AT    = 2,
    parameter int PER_DTACK = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phase_ok,
    input  logic              as_n,
    input  logic              uds_n,
    input  logic              lds_n,
    input  logic              ram_sel,
    input  logic              per_sel,
    input  logic [ROW_W-1:0]  bank_sel,
    input  logic              gnt,
    output logic [ROWS-1:0]   ras,
    output logic [2*ROWS-1:0] cas_cpu,
    output logic              rcmux,
    output logic              buf_en,
    output logic              dtack_n,
    output logic              cpu_claim
);

    localparam int TCNT_W = $clog2(PER_DTACK + 1);
    localparam logic [TCNT_W-1:0] T_MAX   = TCNT_W'(PER_DTACK);
    localparam logic [TCNT_W-1:0] T_RAMDT = TCNT_W'(RAM_DTACK);
    localparam logic [TCNT_W-1:0] T_CAS   = TCNT_W'(CAS_AT);
    localparam logic [TCNT_W-1:0] T_COL   = TCNT_W'(1);

    cyc_state_t         state;
    acc_t               acc;
    logic [ROW_W-1:0]   row;
    logic [TCNT_W-1:0]  tcnt;
    logic               start_now;
    logic               run_ram;
    logic               resume_now;

    assign start_now  = (state == CYC_IDLE) && phase_ok && !as_n && (ram_sel || per_sel);
    assign resume_now = (state == CYC_STRETCH) && phase_ok && !gnt;
    assign run_ram    = (state == CYC_RUN) && (acc.kind == ACC_RAM);
    assign cpu_claim  = run_ram || resume_now || (start_now && ram_sel && !gnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CYC_IDLE;
            acc   <= '{kind: ACC_RAM, upper: 1'b0, lower: 1'b0};
            row   <= '0;
            tcnt  <= '0;
        end else begin
            case (state)
                CYC_IDLE: begin
                    if (start_now) begin
                        acc.kind  <= ram_sel ? ACC_RAM : ACC_PER;
                        acc.upper <= !uds_n;
                        acc.lower <= !lds_n;
                        row       <= bank_sel;
                        tcnt      <= '0;
                        state     <= (ram_sel && gnt) ? CYC_STRETCH : CYC_RUN;
                    end
                end
                CYC_STRETCH: begin
                    if (resume_now) begin
                        state <= CYC_RUN;
                        tcnt  <= '0;
                    end
                end
                CYC_RUN: begin
                    if (as_n)              state <= CYC_IDLE;
                    else if (tcnt != T_MAX) tcnt  <= tcnt + TCNT_W'(1);
                end
                default: state <= CYC_IDLE;
            endcase
        end
    end

    genvar r;
    generate
        for (r = 0; r < ROWS; r++) begin : g_row
            logic hit;
            assign hit              = run_ram && (row == ROW_W'(r));
            assign ras[r]           = hit;
            assign cas_cpu[2*r]     = hit && (tcnt >= T_CAS) && acc.lower;
            assign cas_cpu[2*r + 1] = hit && (tcnt >= T_CAS) && acc.upper;
        end
    endgenerate

    assign rcmux   = run_ram && (tcnt >= T_COL);
    assign buf_en  = run_ram;
    assign dtack_n = !((state == CYC_RUN) &&
                       (tcnt >= ((acc.kind == ACC_RAM) ? T_RAMDT : T_MAX)));

    // R2: a row strobe only ever rises on a start-phase edge
    a_r2_start_phase: assert property (@(posedge clk) disable iff (rst)
        $rose(|ras) |-> $past(phase_ok));

endmodule

// File: rtl/dram_cycle_arbiter.sv
module dram_cycle_arbiter
    import dram_arb_pkg::*;
#(
    parameter int ROWS       = 2,
    parameter int DIV_STAGES = 4,
    parameter int RAM_DTACK  = 2,
    localparam int ROW_W     = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  as_n,
    input  logic                  uds_n,
    input  logic                  lds_n,
    input  logic                  ram_sel,
    input  logic                  per_sel,
    input  logic [ROW_W-1:0]      bank_sel,
    input  logic                  dma_req,
    input  logic                  dma_wp,
    output logic [DIV_STAGES-1:0] div_clk,
    output logic                  dma_gnt,
    output logic [ROWS-1:0]       ras_n,
    output logic [2*ROWS-1:0]     cas_n,
    output logic                  rcmux,
    output logic                  buf_en,
    output logic                  dtack_n
);

    localparam int DMA_ROW   = ROWS - 1;
    localparam int PER_DTACK = RAM_DTACK + PER_EXTRA_CPU_CLKS * (2 << CPU_CLK_BIT);

    logic              phase_ok;
    logic              cpu_claim;
    logic [ROWS-1:0]   ras;
    logic [2*ROWS-1:0] cas_cpu;

    clk_divider #(.STAGES(DIV_STAGES)) u_div (
        .clk(clk), .rst(rst), .div(div_clk), .phase_ok(phase_ok)
    );

    dma_grant u_gnt (
        .clk(clk), .rst(rst), .phase_ok(phase_ok), .dma_req(dma_req),
        .cpu_claim(cpu_claim), .ras_any(|ras), .gnt(dma_gnt)
    );

    cpu_cycle #(
        .ROWS(ROWS), .ROW_W(ROW_W), .RAM_DTACK(RAM_DTACK),
        .CAS_AT(RAM_DTACK), .PER_DTACK(PER_DTACK)
    ) u_cpu (
        .clk(clk), .rst(rst), .phase_ok(phase_ok), .as_n(as_n),
        .uds_n(uds_n), .lds_n(lds_n), .ram_sel(ram_sel), .per_sel(per_sel),
        .bank_sel(bank_sel), .gnt(dma_gnt), .ras(ras), .cas_cpu(cas_cpu),
        .rcmux(rcmux), .buf_en(buf_en), .dtack_n(dtack_n), .cpu_claim(cpu_claim)
    );

    assign ras_n = ~ras;

    genvar r;
    generate
        for (r = 0; r < ROWS; r++) begin : g_cas
            if (r == DMA_ROW) begin : g_dma_row
                assign cas_n[2*r]     = dma_gnt ? ~dma_wp : ~cas_cpu[2*r];
                assign cas_n[2*r + 1] = dma_gnt ? ~dma_wp : ~cas_cpu[2*r + 1];
            end else begin : g_cpu_row
                assign cas_n[2*r]     = ~cas_cpu[2*r];
                assign cas_n[2*r + 1] = ~cas_cpu[2*r + 1];
            end
            // R9: a column strobe needs either DMA ownership or its own row strobe
            a_r9_cas_owner: assert property (@(posedge clk) disable iff (rst)
                (!cas_n[2*r] || !cas_n[2*r + 1]) |-> (dma_gnt || !ras_n[r]));
        end
    endgenerate

    // R5: no CPU row strobe while DMA owns the RAM
    a_r5_gnt_no_ras: assert property (@(posedge clk) disable iff (rst)
        dma_gnt |-> &ras_n);

    // R8: the CPU data buffer stays closed during DMA ownership
    a_r8_buf_closed: assert property (@(posedge clk) disable iff (rst)
        buf_en |-> !dma_gnt);

endmodule

// File: tb/tb_dram_cycle_arbiter.sv
module tb_dram_cycle_arbiter;

    logic       clk = 1'b0;
    logic       rst;
    logic       as_n, uds_n, lds_n, ram_sel, per_sel, dma_req, dma_wp;
    logic [0:0] bank_sel;
    logic [3:0] div_clk;
    logic       dma_gnt;
    logic [1:0] ras_n;
    logic [3:0] cas_n;
    logic       rcmux, buf_en, dtack_n;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    dram_cycle_arbiter dut (
        .clk(clk), .rst(rst), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
        .ram_sel(ram_sel), .per_sel(per_sel), .bank_sel(bank_sel),
        .dma_req(dma_req), .dma_wp(dma_wp), .div_clk(div_clk),
        .dma_gnt(dma_gnt), .ras_n(ras_n), .cas_n(cas_n), .rcmux(rcmux),
        .buf_en(buf_en), .dtack_n(dtack_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_idle();
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
        ram_sel = 1'b0; per_sel = 1'b0; bank_sel = 1'b0;
    endtask

    // Stop at the falling edge just before a start-phase rising edge.
    task automatic wait_phase();
        @(negedge clk);
        while (div_clk[1:0] != 2'b01) @(negedge clk);
    endtask

    task automatic wait_div(input logic [1:0] v);
        @(negedge clk);
        while (div_clk[1:0] != v) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; bus_idle(); dma_req = 1'b0; dma_wp = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 div", div_clk, 4'h0);
        chk("R11 ras", ras_n, 2'b11);
        chk("R11 cas", cas_n, 4'hF);
        chk("R11 dtack", dtack_n, 1);
        chk("R11 buf", buf_en, 0);
        chk("R11 rcmux", rcmux, 0);
        chk("R11 gnt", dma_gnt, 0);
        rst = 1'b0;
    endtask

    task automatic t_divider();
        logic [3:0] prev;
        @(negedge clk);
        prev = div_clk;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R1 divider step", div_clk, 4'(prev + 4'd1));
            prev = div_clk;
        end
    endtask

    task automatic t_ram(input logic bank, input logic u_n, input logic l_n);
        logic [3:0] exp_cas;
        exp_cas = 4'hF;
        if (!u_n) exp_cas[2*bank + 1] = 1'b0;
        if (!l_n) exp_cas[2*bank]     = 1'b0;
        wait_phase();
        as_n = 1'b0; ram_sel = 1'b1; bank_sel = bank; uds_n = u_n; lds_n = l_n;
        @(negedge clk);
        chk("R3 ras at start", ras_n, bank ? 2'b01 : 2'b10);
        chk("R3 row select", rcmux, 0);
        chk("R3 buffer on", buf_en, 1);
        chk("R3 dtack early", dtack_n, 1);
        @(negedge clk);
        chk("R3 column select", rcmux, 1);
        chk("R4 cas early", cas_n, 4'hF);
        @(negedge clk);
        chk("R4 cas bytes", cas_n, exp_cas);
        chk("R3 dtack", dtack_n, 0);
        bus_idle();
        @(negedge clk);
        chk("R3 release ras", ras_n, 2'b11);
        chk("R3 release dtack", dtack_n, 1);
        chk("R3 release buf", buf_en, 0);
        chk("R4 release cas", cas_n, 4'hF);
    endtask

    task automatic t_phase_wait();
        wait_div(2'b10);
        as_n = 1'b0; ram_sel = 1'b1; bank_sel = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 no start off phase", ras_n, 2'b11);
        @(negedge clk);
        chk("R2 start on phase", ras_n, 2'b10);
        repeat (2) @(negedge clk);
        bus_idle();
        @(negedge clk);
    endtask

    task automatic t_grant_and_wp();
        wait_div(2'b10);
        dma_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 grant waits for phase", dma_gnt, 0);
        @(negedge clk);
        chk("R5 grant at phase", dma_gnt, 1);
        dma_wp = 1'b1; #1;
        chk("R9 dma cas low", cas_n, 4'b0011);
        dma_wp = 1'b0; #1;
        chk("R9 dma cas high", cas_n, 4'hF);
        wait_div(2'b10);
        dma_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 grant holds off phase", dma_gnt, 1);
        @(negedge clk);
        chk("R6 grant drops", dma_gnt, 0);
    endtask

    task automatic t_stretch();
        wait_phase();
        dma_req = 1'b1;
        @(negedge clk);
        chk("R5 grant idle", dma_gnt, 1);
        wait_phase();
        as_n = 1'b0; ram_sel = 1'b1; bank_sel = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
        repeat (8) @(negedge clk);
        chk("R8 stretch dtack", dtack_n, 1);
        chk("R8 stretch buf", buf_en, 0);
        chk("R8 stretch ras", ras_n, 2'b11);
        wait_phase();
        dma_req = 1'b0;
        @(negedge clk);
        chk("R6 release", dma_gnt, 0);
        repeat (3) @(negedge clk);
        chk("R8 waits next phase", ras_n, 2'b11);
        @(negedge clk);
        chk("R8 resume ras", ras_n, 2'b10);
        chk("R8 resume buf", buf_en, 1);
        repeat (2) @(negedge clk);
        chk("R8 resume dtack", dtack_n, 0);
        bus_idle();
        @(negedge clk);
    endtask

    task automatic t_holdoff();
        wait_phase();
        as_n = 1'b0; ram_sel = 1'b1; bank_sel = 1'b1; uds_n = 1'b0; lds_n = 1'b0;
        @(negedge clk);
        dma_req = 1'b1;
        repeat (10) @(negedge clk);
        chk("R7 held during cpu cycle", dma_gnt, 0);
        chk("R7 cpu keeps ras", ras_n, 2'b01);
        bus_idle();
        @(negedge clk);
        chk("R7 held on release edge", dma_gnt, 0);
        wait_phase();
        @(negedge clk);
        chk("R7 pending request granted", dma_gnt, 1);
        dma_req = 1'b0;
        wait_phase();
        @(negedge clk);
        // Tie: CPU start and DMA request on the same phase edge
        wait_phase();
        as_n = 1'b0; ram_sel = 1'b1; bank_sel = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
        dma_req = 1'b1;
        @(negedge clk);
        chk("R7 same-edge start blocks grant", dma_gnt, 0);
        chk("R7 same-edge cpu runs", ras_n, 2'b10);
        bus_idle();
        @(negedge clk);
        wait_phase();
        @(negedge clk);
        chk("R7 granted after tie", dma_gnt, 1);
        dma_req = 1'b0;
        wait_phase();
        @(negedge clk);
    endtask

    task automatic t_peripheral();
        wait_phase();
        as_n = 1'b0; per_sel = 1'b1; uds_n = 1'b0;
        for (int i = 0; i <= 6; i++) begin
            @(negedge clk);
            chk("R10 serial dtack", dtack_n, (i == 6) ? 1'b0 : 1'b1);
            chk("R10 serial no ras", ras_n, 2'b11);
            chk("R10 serial no cas", cas_n, 4'hF);
        end
        bus_idle();
        @(negedge clk);
        chk("R10 serial release", dtack_n, 1);
    endtask

    task automatic t_reset_mid();
        wait_phase();
        dma_req = 1'b1;
        @(negedge clk);
        dma_req = 1'b0;
        wait_phase();
        as_n = 1'b0; ram_sel = 1'b1; bank_sel = 1'b0;
        repeat (3) @(negedge clk);
        do_reset();
        chk("R11 gnt after mid reset", dma_gnt, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        t_divider();
        t_ram(1'b0, 1'b0, 1'b0);
        t_ram(1'b1, 1'b0, 1'b1);
        t_ram(1'b0, 1'b1, 1'b0);
        t_phase_wait();
        t_grant_and_wp();
        t_stretch();
        t_holdoff();
        t_peripheral();
        t_reset_mid();
        t_ram(1'b1, 1'b1, 1'b0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule